// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A free-running watchdog counter clocked by the system clock. Software picks the timeout with a 2-bit select. A clock-mode setting made of a fast-mode bit and a 2-bit divide code scales that timeout. When the chosen count completes, the block sets a sticky warning (interrupt) flag. If no restart arrives within a fixed grace window of 512 clocks, it sets a sticky reset flag. At the same moment it can emit a one-cycle reset request, gated by a reset-enable bit.

Software keeps the system alive by pulsing the kick strobe. A kick restarts the main count and abandons any grace window in progress. Any change of the timeout select or the clock mode also restarts the count, so the new period runs from zero. Each flag has its own clear strobe. The main counter keeps running after a timeout, so the warning flag can also serve as a periodic time base.

Top module: `wdt_two_stage`

## Requirements
- R1: The warning flag rises exactly 2^(B + STEP*sel_i) clocks after the edge that restarted the count, where STEP defaults to 3 and B is the base exponent from R2.
- R2: The base exponent B comes from the clock mode. With cdiv_i=00, it is BASE_FAST (15) when fast_i=1 and BASE_DIV1 (16) when fast_i=0. With cdiv_i=01 or 10 it is BASE_MID (17), and with cdiv_i=11 it is BASE_SLOW (25).
- R3: The reset flag rises exactly GRACE (512) clocks after the warning flag rises, whether or not software has cleared the warning flag. A further timeout inside an open grace window does not restart that window.
- R4: rst_req_o is high for a single cycle, the cycle in which the grace window expires, and only when rst_en_i was 1 at that edge. The reset flag is set either way.
- R5: A kick clears the main counter and closes any open grace window. A kick on the same edge as a timeout or a grace expiry suppresses that event.
- R6: Both flags stay set until their clear strobe, clr_int_i or clr_rst_i. If a flag's set and clear fall on the same edge, the set wins.
- R7: A change of sel_i, fast_i or cdiv_i relative to the previous cycle restarts the count and closes the grace window, just as a kick does. The configuration register resets to sel=00, fast=0, cdiv=10.
- R8: While reset is held and after it is released, all three outputs are 0 until the first timeout.
- R9: After a timeout the main counter wraps to zero and counts again, so an uncleared flag stays set and a cleared warning flag rises again one period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Timeout select |
| fast_i | input | 1 | Fast clock-mode bit |
| cdiv_i | input | 2 | Clock divide code |
| kick_i | input | 1 | Restart strobe |
| rst_en_i | input | 1 | Enables the reset request |
| clr_int_i | input | 1 | Clears the warning flag |
| clr_rst_i | input | 1 | Clears the reset flag |
| int_flag_o | output | 1 | Sticky warning flag |
| rst_flag_o | output | 1 | Sticky reset flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two kinds of event can land on the same edge. A kick can coincide with a timeout or a grace expiry. A clear strobe can coincide with the setting of its flag. The bench provokes both by counting edges from a known restart, then placing the kick or clear on the exact edge where the timeout completes. It then checks that the kick suppresses the warning flag and that the flag survives the clear. A behavioural model holding integer counters judges every cycle, and directed checks measure the period for all mode and select codes and the 512-clock grace gap, using reduced exponents.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic [1:0] sel;
    logic       fast;
    logic [1:0] cdiv;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_RST = '{sel: 2'b00, fast: 1'b0, cdiv: 2'b10};
endpackage

// File: rtl/wdt_exp_sel.sv
module wdt_exp_sel #(
  parameter int BASE_FAST = 15,
  parameter int BASE_DIV1 = 16,
  parameter int BASE_MID  = 17,
  parameter int BASE_SLOW = 25,
  parameter int STEP      = 3,
  parameter int EXP_W     = 6
) (
  input  wdt_pkg::wdt_cfg_t cfg_i,
  output logic [EXP_W-1:0]  exp_o
);
  int base;

  always_comb begin
    unique case (cfg_i.cdiv)
      2'b00:   base = cfg_i.fast ? BASE_FAST : BASE_DIV1;
      2'b11:   base = BASE_SLOW;
      default: base = BASE_MID;
    endcase
    exp_o = EXP_W'(base + STEP * int'(cfg_i.sel));
  end
endmodule

// File: rtl/wdt_main_cnt.sv
module wdt_main_cnt #(
  parameter int CNT_W = 34,
  parameter int EXP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             term_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // 2^exp - 1; exp == CNT_W wraps to all ones
  assign last   = (CNT_W'(1) << exp_i) - CNT_W'(1);
  assign term_o = !restart_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || term_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_grace_cnt.sv
module wdt_grace_cnt #(
  parameter int GRACE = 512,
  localparam int GW   = $clog2(GRACE)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic start_i,
  output logic expire_o
);
  logic          active_q;
  logic [GW-1:0] gcnt_q;

  assign expire_o = !restart_i && active_q && (gcnt_q == GW'(GRACE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      gcnt_q   <= '0;
    end else if (restart_i) begin
      active_q <= 1'b0;
      gcnt_q   <= '0;
    end else if (active_q) begin
      // a timeout inside an open window is ignored
      active_q <= !expire_o;
      gcnt_q   <= expire_o ? '0 : gcnt_q + GW'(1);
    end else if (start_i) begin
      active_q <= 1'b1;
      gcnt_q   <= '0;
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int BASE_FAST = 15,
  parameter int BASE_DIV1 = 16,
  parameter int BASE_MID  = 17,
  parameter int BASE_SLOW = 25,
  parameter int STEP      = 3,
  parameter int GRACE     = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       fast_i,
  input  logic [1:0] cdiv_i,
  input  logic       kick_i,
  input  logic       rst_en_i,
  input  logic       clr_int_i,
  input  logic       clr_rst_i,
  output logic       int_flag_o,
  output logic       rst_flag_o,
  output logic       rst_req_o
);
  import wdt_pkg::*;

  localparam int MAX_B01 = (BASE_FAST > BASE_DIV1) ? BASE_FAST : BASE_DIV1;
  localparam int MAX_B23 = (BASE_MID > BASE_SLOW) ? BASE_MID : BASE_SLOW;
  localparam int MAX_B   = (MAX_B01 > MAX_B23) ? MAX_B01 : MAX_B23;
  localparam int CNT_W   = MAX_B + 3 * STEP;
  localparam int EXP_W   = $clog2(CNT_W + 1);

  wdt_cfg_t         cfg, cfg_q;
  logic [EXP_W-1:0] exp_w;
  logic             restart, term, expire;

  assign cfg     = '{sel: sel_i, fast: fast_i, cdiv: cdiv_i};
  assign restart = kick_i || (cfg != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg;
  end

  wdt_exp_sel #(
    .BASE_FAST(BASE_FAST), .BASE_DIV1(BASE_DIV1), .BASE_MID(BASE_MID),
    .BASE_SLOW(BASE_SLOW), .STEP(STEP), .EXP_W(EXP_W)
  ) u_exp (
    .cfg_i (cfg),
    .exp_o (exp_w)
  );

  wdt_main_cnt #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_main (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .exp_i     (exp_w),
    .term_o    (term)
  );

  wdt_grace_cnt #(.GRACE(GRACE)) u_grace (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .start_i   (term),
    .expire_o  (expire)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_flag_o <= 1'b0;
      rst_flag_o <= 1'b0;
      rst_req_o  <= 1'b0;
    end else begin
      if (term)           int_flag_o <= 1'b1;
      else if (clr_int_i) int_flag_o <= 1'b0;
      if (expire)         rst_flag_o <= 1'b1;
      else if (clr_rst_i) rst_flag_o <= 1'b0;
      rst_req_o <= expire && rst_en_i;
    end
  end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic kick_i,
  input logic rst_en_i,
  input logic clr_int_i,
  input logic clr_rst_i,
  input logic int_flag_o,
  input logic rst_flag_o,
  input logic rst_req_o
);
  // R4
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R4
  req_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rst_flag_o);
  // R4
  req_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(rst_en_i));
  // R6
  int_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_flag_o) |-> $past(clr_int_i));
  // R6
  rst_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_flag_o) |-> $past(clr_rst_i));
  // R5
  kick_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !rst_req_o);
  // R5
  kick_no_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !$rose(int_flag_o));
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .kick_i     (kick_i),
  .rst_en_i   (rst_en_i),
  .clr_int_i  (clr_int_i),
  .clr_rst_i  (clr_rst_i),
  .int_flag_o (int_flag_o),
  .rst_flag_o (rst_flag_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/wdt_two_stage_tb.sv
`timescale 1ns/1ps
module wdt_two_stage_tb;
  localparam int BF = 2, BD = 3, BM = 4, BS = 5, ST = 2, GR = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = 2'b00, cdiv = 2'b10;
  logic fast = 1'b0, kick = 1'b0, rst_en = 1'b0, clr_int = 1'b0, clr_rst = 1'b0;
  logic int_flag, rst_flag, rst_req;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_two_stage #(.BASE_FAST(BF), .BASE_DIV1(BD), .BASE_MID(BM),
                  .BASE_SLOW(BS), .STEP(ST), .GRACE(GR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .fast_i(fast), .cdiv_i(cdiv),
    .kick_i(kick), .rst_en_i(rst_en), .clr_int_i(clr_int), .clr_rst_i(clr_rst),
    .int_flag_o(int_flag), .rst_flag_o(rst_flag), .rst_req_o(rst_req)
  );

  function automatic int period(input logic f, input logic [1:0] c, input logic [1:0] s);
    int b;
    if (c == 2'b00) b = f ? BF : BD;
    else if (c == 2'b11) b = BS;
    else b = BM;
    return 1 << (b + ST * int'(s));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_grace = 0;
  bit m_act = 0, m_int = 0, m_rst = 0, m_req = 0;
  logic [4:0] m_cfg_prev = 5'b00010;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_grace = 0; m_act = 0; m_int = 0; m_rst = 0; m_req = 0;
      m_cfg_prev = 5'b00010;
    end else begin
      bit rs, tm, ex;
      rs = kick || ({sel, fast, cdiv} != m_cfg_prev);
      tm = !rs && (m_cnt == period(fast, cdiv, sel) - 1);
      ex = !rs && m_act && (m_grace == GR - 1);
      if (rs) begin
        m_cnt = 0; m_act = 0; m_grace = 0;
      end else begin
        m_cnt = tm ? 0 : m_cnt + 1;
        if (m_act) begin
          m_grace = ex ? 0 : m_grace + 1;
          m_act = !ex;
        end else if (tm) begin
          m_act = 1; m_grace = 0;
        end
      end
      m_int = tm ? 1 : (clr_int ? 0 : m_int);
      m_rst = ex ? 1 : (clr_rst ? 0 : m_rst);
      m_req = ex && rst_en;
      m_cfg_prev = {sel, fast, cdiv};
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 int_flag model", int'(int_flag), int'(m_int));
    chk("R3 rst_flag model", int'(rst_flag), int'(m_rst));
    chk("R4 rst_req model", int'(rst_req), int'(m_req));
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // restart with new config, return edges until warning flag
  task automatic measure(input logic f, input logic [1:0] c, input logic [1:0] s, output int cyc);
    fast = f; cdiv = c; sel = s; kick = 1; clr_int = 1; clr_rst = 1;
    step();
    kick = 0; clr_int = 0; clr_rst = 0;
    cyc = 0;
    while (!int_flag && cyc < 5000) begin step(); cyc++; end
  endtask

  initial begin
    int cyc;
    @(negedge clk);
    // R8 reset state
    chk("R8 int reset", int'(int_flag), 0);
    chk("R8 rst reset", int'(rst_flag), 0);
    chk("R8 req reset", int'(rst_req), 0);
    step(); rst_n = 1;
    step();
    chk("R8 int after release", int'(int_flag), 0);

    // R1 R2 R7: every mode and select
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 2; f++) begin
        if (c != 0 && f == 1) continue;
        for (int s = 0; s < 4; s++) begin
          measure(f[0], c[1:0], s[1:0], cyc);
          chk($sformatf("R1 R2 period f=%0d c=%0d s=%0d", f, c, s), cyc,
              period(f[0], c[1:0], s[1:0]));
        end
      end

    // R3 R4 grace with reset enabled
    rst_en = 1;
    measure(1'b0, 2'b01, 2'b00, cyc);
    clr_int = 1; step(); clr_int = 0; cyc = 1;
    while (!rst_flag && cyc < 2000) begin step(); cyc++; end
    chk("R3 grace length", cyc, GR);
    chk("R4 req with enable", int'(rst_req), 1);
    step();
    chk("R4 req single cycle", int'(rst_req), 0);
    chk("R6 rst flag sticky", int'(rst_flag), 1);
    clr_rst = 1; step(); clr_rst = 0;
    chk("R6 rst flag cleared", int'(rst_flag), 0);

    // R4 disabled
    rst_en = 0;
    measure(1'b0, 2'b01, 2'b00, cyc);
    for (int i = 0; i < GR + 2; i++) begin
      step();
      if (rst_flag) break;
    end
    chk("R4 flag without enable", int'(rst_flag), 1);
    chk("R4 no req without enable", int'(rst_req), 0);

    // R5 periodic kicks prevent warning (N=16)
    measure(1'b0, 2'b10, 2'b00, cyc);
    clr_int = 1; clr_rst = 1; kick = 1; step(); clr_int = 0; clr_rst = 0;
    for (int i = 0; i < 200; i++) begin
      kick = (i % 10 == 0); step();
    end
    kick = 0;
    chk("R5 kicks hold off warning", int'(int_flag), 0);

    // R5 kick on the terminal edge
    kick = 1; step(); kick = 0;
    repeat (15) step();
    kick = 1; step(); kick = 0;
    chk("R5 kick beats timeout", int'(int_flag), 0);
    repeat (15) step();
    chk("R9 counter restarted after kick", int'(int_flag), 0);
    step();
    chk("R9 warning one period later", int'(int_flag), 1);

    // R5 kick inside grace window
    clr_int = 1; clr_rst = 1; kick = 1; step(); kick = 0; clr_int = 0; clr_rst = 0;
    repeat (16 + 100) step();
    kick = 1; step(); kick = 0;
    repeat (420) step();
    chk("R5 kick cancels grace", int'(rst_flag), 0);

    // R6 clear on the same edge as set
    clr_int = 1; kick = 1; step(); kick = 0; clr_int = 0;
    repeat (15) step();
    clr_int = 1; step(); clr_int = 0;
    chk("R6 set beats clear", int'(int_flag), 1);
    clr_int = 1; step(); clr_int = 0;
    chk("R6 clear works", int'(int_flag), 0);

    // R7 config change mid count restarts
    kick = 1; step(); kick = 0;
    repeat (10) step();
    cdiv = 2'b01; step();
    repeat (15) step();
    chk("R7 change restarted count", int'(int_flag), 0);
    step();
    chk("R7 new period from change", int'(int_flag), 1);

    repeat (5) step();
    finish_run();
  end
endmodule